// File: doc/BRIEF.md
# Flash Initialization Command Sequencer

This block sends a short, programmable list of setup commands to a serial flash device before the rest of the system may read from it. Each list slot holds an opcode, a 32-bit data word and a byte count. When started, the sequencer walks the slots in order. For each slot it drives one single-line serial transaction: chip select goes low, the opcode is shifted out, then the requested number of data bytes follow, and chip select goes high again. A typical list has a write-enable opcode with no data, followed by a status-register write that carries two data bytes.

The list is filled through a simple write port while the sequencer is idle. A count register chooses how many slots run. Inside a transaction the data bytes go out lowest byte first, and each byte goes out most significant bit first. Until the whole list has been sent, a ready flag stays low and incoming read requests are not granted.

Top module: `flash_init_seq`

## Requirements
- R1: In the cycle after reset, `spi_cs_n` is 1, `spi_sck` is 0, `seq_ready` is 0 and `rd_grant` is 0. After reset every slot and the count hold zero.
- R2: When `seq_go` is sampled with an effective count of zero, `seq_ready` is 1 in the following cycle and no chip-select frame is produced.
- R3: With an effective count of N > 0, exactly N chip-select-low frames are produced, one for each slot 0..N-1, in ascending slot order. `spi_cs_n` stays high for at least `HALF_DIV` clock cycles between frames.
- R4: A frame sends 8 opcode bits and then 8 bits for each data byte. Data byte k is `data[8k+7:8k]`, and bytes are sent with k ascending. Every byte is sent MSB first. Bits are valid at the rising edge of `spi_sck`.
- R5: A slot with length 0 produces an 8-bit frame that holds only the opcode.
- R6: A length field of 5, 6 or 7 is treated as 4. The frame carries 40 bits.
- R7: `rd_grant` is 1 only while both `rd_req` and `seq_ready` are 1.
- R8: Writes to slots or to the count while a run is in progress are ignored. Frames later in that run keep the old contents.
- R9: A count value greater than `DEPTH` runs `DEPTH` slots.
- R10: `spi_sck` idles low, and `spi_mosi` does not change while `spi_sck` is high.
- R11: `seq_ready` stays 1 until the next `seq_go`. A `seq_go` sampled while a run is in progress is ignored. A `seq_go` sampled when idle or ready starts a new run, and `seq_ready` is 0 in the cycle after it.
- R12: `spi_sck` toggles only while `spi_cs_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for one slot |
| cfg_idx | input | IDX_W | Slot index to write |
| cfg_cmd | input | 8 | Opcode for the slot |
| cfg_data | input | 32 | Data word for the slot |
| cfg_len | input | 3 | Data byte count (values above 4 are clamped) |
| cnt_we | input | 1 | Write strobe for the count register |
| cnt_val | input | CNT_IN_W | Number of slots to run |
| seq_go | input | 1 | Start a run |
| seq_ready | output | 1 | The whole list has been sent |
| rd_req | input | 1 | Normal read request |
| rd_grant | output | 1 | Read request allowed through |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |

## Verification
If the slot index is wrong, a frame carries another slot's opcode or data. This shows up when the frame closes, within a few hundred clock cycles of the fault. If the bit counter or the length clamp is wrong, the frame has the wrong bit count when chip select rises. If byte selection is wrong, bytes appear swapped inside a multi-byte frame. If the controller holds the wrong state, the frame count is off, `seq_ready` rises early or never rises, or `rd_grant` opens during a run. The grant fault is visible in the first cycle after the start.

// File: rtl/fis_pkg.sv
package fis_pkg;

    localparam int CMD_W      = 8;
    localparam int WORD_W     = 32;
    localparam int LEN_W      = 3;
    localparam int MAX_BYTES  = WORD_W / 8;
    localparam int FRAME_W    = CMD_W + WORD_W;
    localparam int BITCNT_W   = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic [CMD_W-1:0]  cmd;
        logic [WORD_W-1:0] data;
        logic [LEN_W-1:0]  len;
    } fis_slot_t;

    typedef enum logic [2:0] {
        SH_IDLE,
        SH_SETUP,
        SH_LOW,
        SH_HIGH,
        SH_HOLD,
        SH_GAP
    } fis_sh_state_e;

    typedef enum logic [1:0] {
        C_IDLE,
        C_ISSUE,
        C_WAIT,
        C_DONE
    } fis_ctl_state_e;

    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] l);
        return (int'(l) > MAX_BYTES) ? LEN_W'(MAX_BYTES) : l;
    endfunction

    function automatic logic [BITCNT_W-1:0] frame_bits(input logic [LEN_W-1:0] l);
        return BITCNT_W'(CMD_W + 8 * int'(clamp_len(l)));
    endfunction

    // Opcode in the top byte, then data bytes with the lowest byte first,
    // so that shifting from the MSB gives the wire order.
    function automatic logic [FRAME_W-1:0] pack_frame(input fis_slot_t s);
        logic [FRAME_W-1:0] v;
        v[FRAME_W-1 -: CMD_W] = s.cmd;
        for (int k = 0; k < MAX_BYTES; k++) begin
            v[WORD_W-1-8*k -: 8] = s.data[8*k +: 8];
        end
        return v;
    endfunction

endpackage

// File: rtl/fis_slot_table.sv
module fis_slot_table
    import fis_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  fis_slot_t        wr_slot,
    input  logic [IDX_W-1:0] rd_idx,
    output fis_slot_t        rd_slot
);

    fis_slot_t rows [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst) begin
                rows[g] <= '0;
            end else if (wr_en && (int'(wr_idx) == g)) begin
                rows[g] <= wr_slot;
            end
        end
    end

    always_comb begin
        rd_slot = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (int'(rd_idx) == i) rd_slot = rows[i];
        end
    end

endmodule

// File: rtl/fis_shifter.sv
module fis_shifter
    import fis_pkg::*;
#(
    parameter int HALF_DIV = 2,
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  fis_slot_t slot,
    output logic      done,
    output logic      cs_n,
    output logic      sck,
    output logic      mosi
);

    fis_sh_state_e       st_q;
    logic [DIV_W-1:0]    div_q;
    logic [FRAME_W-1:0]  sr_q;
    logic [BITCNT_W-1:0] left_q;
    logic                phase_end;

    assign phase_end = (int'(div_q) == HALF_DIV - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SH_IDLE;
            div_q  <= '0;
            sr_q   <= '0;
            left_q <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (st_q == SH_IDLE) begin
                div_q <= '0;
                if (start) begin
                    sr_q   <= pack_frame(slot);
                    left_q <= frame_bits(slot.len);
                    st_q   <= SH_SETUP;
                end
            end else if (!phase_end) begin
                div_q <= div_q + 1'b1;
            end else begin
                div_q <= '0;
                unique case (st_q)
                    SH_SETUP: st_q <= SH_LOW;
                    SH_LOW:   st_q <= SH_HIGH;
                    SH_HIGH: begin
                        sr_q   <= {sr_q[FRAME_W-2:0], 1'b0};
                        left_q <= left_q - 1'b1;
                        st_q   <= (left_q == BITCNT_W'(1)) ? SH_HOLD : SH_LOW;
                    end
                    SH_HOLD:  st_q <= SH_GAP;
                    SH_GAP: begin
                        st_q <= SH_IDLE;
                        done <= 1'b1;
                    end
                    default:  st_q <= SH_IDLE;
                endcase
            end
        end
    end

    assign cs_n = (st_q == SH_IDLE) || (st_q == SH_GAP);
    assign sck  = (st_q == SH_HIGH);
    assign mosi = ((st_q == SH_LOW) || (st_q == SH_HIGH)) ? sr_q[FRAME_W-1] : 1'b0;

endmodule

// File: rtl/fis_ctrl.sv
module fis_ctrl
    import fis_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int CNT_IN_W = 8,
    localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int EFF_W   = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                go,
    input  logic                cnt_we,
    input  logic [CNT_IN_W-1:0] cnt_val,
    input  logic                sh_done,
    output logic                sh_start,
    output logic [IDX_W-1:0]    idx,
    output logic                busy,
    output logic                ready
);

    fis_ctl_state_e      st_q;
    logic [CNT_IN_W-1:0] cnt_q;
    logic [EFF_W-1:0]    eff;
    logic [IDX_W-1:0]    idx_q;
    logic                last;

    assign eff  = (int'(cnt_q) > DEPTH) ? EFF_W'(DEPTH) : EFF_W'(cnt_q);
    assign last = (EFF_W'(idx_q) == eff - 1'b1);
    assign busy = (st_q == C_ISSUE) || (st_q == C_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_we && !busy) begin
            cnt_q <= cnt_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= C_IDLE;
            idx_q <= '0;
        end else begin
            unique case (st_q)
                C_IDLE, C_DONE: begin
                    if (go) begin
                        idx_q <= '0;
                        st_q  <= (eff == '0) ? C_DONE : C_ISSUE;
                    end
                end
                C_ISSUE: st_q <= C_WAIT;
                C_WAIT: begin
                    if (sh_done) begin
                        if (last) begin
                            st_q <= C_DONE;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                            st_q  <= C_ISSUE;
                        end
                    end
                end
                default: st_q <= C_IDLE;
            endcase
        end
    end

    assign sh_start = (st_q == C_ISSUE);
    assign idx      = idx_q;
    assign ready    = (st_q == C_DONE);

endmodule

// File: rtl/flash_init_seq.sv
module flash_init_seq
    import fis_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int HALF_DIV = 2,
    parameter int CNT_IN_W = 8,
    localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [7:0]          cfg_cmd,
    input  logic [31:0]         cfg_data,
    input  logic [2:0]          cfg_len,
    input  logic                cnt_we,
    input  logic [CNT_IN_W-1:0] cnt_val,
    input  logic                seq_go,
    output logic                seq_ready,
    input  logic                rd_req,
    output logic                rd_grant,
    output logic                spi_cs_n,
    output logic                spi_sck,
    output logic                spi_mosi
);

    fis_slot_t        wr_slot;
    fis_slot_t        cur_slot;
    logic [IDX_W-1:0] cur_idx;
    logic             busy;
    logic             sh_start;
    logic             sh_done;

    assign wr_slot = '{cmd: cfg_cmd, data: cfg_data, len: cfg_len};

    fis_slot_table #(.DEPTH(DEPTH)) u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we && !busy),
        .wr_idx  (cfg_idx),
        .wr_slot (wr_slot),
        .rd_idx  (cur_idx),
        .rd_slot (cur_slot)
    );

    fis_ctrl #(.DEPTH(DEPTH), .CNT_IN_W(CNT_IN_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .go       (seq_go),
        .cnt_we   (cnt_we),
        .cnt_val  (cnt_val),
        .sh_done  (sh_done),
        .sh_start (sh_start),
        .idx      (cur_idx),
        .busy     (busy),
        .ready    (seq_ready)
    );

    fis_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .start (sh_start),
        .slot  (cur_slot),
        .done  (sh_done),
        .cs_n  (spi_cs_n),
        .sck   (spi_sck),
        .mosi  (spi_mosi)
    );

    assign rd_grant = rd_req && seq_ready;

endmodule

// File: rtl/fis_checker.sv
module fis_checker (
    input logic clk,
    input logic rst,
    input logic seq_go,
    input logic seq_ready,
    input logic rd_req,
    input logic rd_grant,
    input logic spi_cs_n,
    input logic spi_sck,
    input logic spi_mosi
);

    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (spi_cs_n && !spi_sck && !seq_ready && !rd_grant));

    a_r7_grant_needs_ready: assert property (@(posedge clk) disable iff (rst)
        rd_grant |-> (seq_ready && rd_req));

    a_r10_mosi_stable: assert property (@(posedge clk) disable iff (rst)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

    a_r12_sck_quiet: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sck);

    a_r11_ready_holds: assert property (@(posedge clk) disable iff (rst)
        (seq_ready && !seq_go) |=> seq_ready);

    a_r11_ready_falls_on_go: assert property (@(posedge clk) disable iff (rst)
        $fell(seq_ready) |-> $past(seq_go));

endmodule

bind flash_init_seq fis_checker u_fis_chk (
    .clk       (clk),
    .rst       (rst),
    .seq_go    (seq_go),
    .seq_ready (seq_ready),
    .rd_req    (rd_req),
    .rd_grant  (rd_grant),
    .spi_cs_n  (spi_cs_n),
    .spi_sck   (spi_sck),
    .spi_mosi  (spi_mosi)
);

// File: tb/flash_init_seq_tb_top.sv
module flash_init_seq_tb_top;

    localparam int DEPTH    = 8;
    localparam int HALF_DIV = 2;
    localparam int CNT_IN_W = 8;
    localparam int IDX_W    = $clog2(DEPTH);

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                cfg_we = 1'b0;
    logic [IDX_W-1:0]    cfg_idx = '0;
    logic [7:0]          cfg_cmd = '0;
    logic [31:0]         cfg_data = '0;
    logic [2:0]          cfg_len = '0;
    logic                cnt_we = 1'b0;
    logic [CNT_IN_W-1:0] cnt_val = '0;
    logic                seq_go = 1'b0;
    logic                rd_req = 1'b0;
    logic                seq_ready, rd_grant, spi_cs_n, spi_sck, spi_mosi;

    int errors = 0;
    int checks = 0;

    // Bench model of the slot list.
    logic [7:0]  m_cmd  [DEPTH];
    logic [31:0] m_data [DEPTH];
    logic [2:0]  m_len  [DEPTH];
    int          m_cnt = 0;

    // Frame log captured from the serial pins.
    logic [39:0] f_val  [64];
    int          f_bits [64];
    int          f_num = 0;
    logic [39:0] cap = '0;
    int          cap_bits = 0;

    always #5 clk = ~clk;

    flash_init_seq #(.DEPTH(DEPTH), .HALF_DIV(HALF_DIV), .CNT_IN_W(CNT_IN_W)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_cmd(cfg_cmd),
        .cfg_data(cfg_data), .cfg_len(cfg_len), .cnt_we(cnt_we), .cnt_val(cnt_val),
        .seq_go(seq_go), .seq_ready(seq_ready), .rd_req(rd_req), .rd_grant(rd_grant),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi)
    );

    always @(posedge spi_sck) begin
        if (!rst && spi_cs_n === 1'b0) begin
            cap      = {cap[38:0], spi_mosi};
            cap_bits = cap_bits + 1;
        end
    end

    always @(posedge spi_cs_n) begin
        if (!rst && cap_bits > 0 && f_num < 64) begin
            f_val[f_num]  = cap;
            f_bits[f_num] = cap_bits;
            f_num         = f_num + 1;
        end
        cap_bits = 0;
        cap      = '0;
    end

    function automatic int exp_len(input logic [2:0] l);
        return (l > 3'd4) ? 4 : int'(l);
    endfunction

    function automatic logic [39:0] exp_frame(input logic [7:0] c, input logic [31:0] d,
                                              input logic [2:0] l);
        logic [39:0] v;
        int n;
        n = exp_len(l);
        v = {32'h0, c};
        for (int k = 0; k < n; k++) v = {v[31:0], d[8*k +: 8]};
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_slot(input int i, input logic [7:0] c, input logic [31:0] d,
                           input logic [2:0] l, input bit model);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = IDX_W'(i); cfg_cmd = c; cfg_data = d; cfg_len = l;
        @(negedge clk);
        cfg_we = 1'b0;
        if (model) begin
            m_cmd[i] = c; m_data[i] = d; m_len[i] = l;
        end
    endtask

    task automatic wr_cnt(input int n);
        @(negedge clk);
        cnt_we = 1'b1; cnt_val = CNT_IN_W'(n);
        @(negedge clk);
        cnt_we = 1'b0;
        m_cnt = n;
    endtask

    // Starts a run, optionally pokes the design while busy, then compares frames.
    task automatic run_and_check(input string tag, input bit poke);
        int n;
        int wd;
        n = (m_cnt > DEPTH) ? DEPTH : m_cnt;
        f_num = 0;
        rd_req = 1'b1;
        @(negedge clk);
        seq_go = 1'b1;
        @(negedge clk);
        seq_go = 1'b0;
        if (n == 0) begin
            check(seq_ready === 1'b1, "R2 ready after zero-count go", 64'(seq_ready), 1);
        end else begin
            check(seq_ready === 1'b0, "R11 ready low after go", 64'(seq_ready), 0);
            check(rd_grant === 1'b0, "R7 grant blocked during run", 64'(rd_grant), 0);
            if (poke) begin
                // R8: slot and count writes during a run are dropped
                wr_slot(n - 1, 8'hEE, 32'hDEAD_BEEF, 3'd3, 1'b0);
                @(negedge clk);
                cnt_we = 1'b1; cnt_val = '0;
                @(negedge clk);
                cnt_we = 1'b0;
                // R11: go while busy is ignored
                seq_go = 1'b1;
                @(negedge clk);
                seq_go = 1'b0;
            end
        end
        wd = 0;
        while (seq_ready !== 1'b1 && wd < 20000) begin
            @(negedge clk);
            wd++;
        end
        check(wd < 20000, {tag, " R11 ready reached"}, 64'(wd), 0);
        check(rd_grant === 1'b1, "R7 grant after ready", 64'(rd_grant), 1);
        check(f_num == n, {tag, " R3 frame count"}, 64'(f_num), 64'(n));
        for (int i = 0; i < n && i < f_num; i++) begin
            check(f_bits[i] == 8 * (1 + exp_len(m_len[i])), {tag, " R4 R6 frame bits"},
                  64'(f_bits[i]), 64'(8 * (1 + exp_len(m_len[i]))));
            check(f_val[i] == exp_frame(m_cmd[i], m_data[i], m_len[i]),
                  {tag, " R4 R8 frame content"}, 64'(f_val[i]),
                  64'(exp_frame(m_cmd[i], m_data[i], m_len[i])));
        end
        repeat (5) @(negedge clk);
        check(seq_ready === 1'b1, {tag, " R11 ready holds"}, 64'(seq_ready), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_F15));
        for (int i = 0; i < DEPTH; i++) begin
            m_cmd[i] = '0; m_data[i] = '0; m_len[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rd_req = 1'b1;
        @(negedge clk);
        check(spi_cs_n === 1'b1, "R1 cs_n after reset", 64'(spi_cs_n), 1);
        check(spi_sck === 1'b0, "R1 sck after reset", 64'(spi_sck), 0);
        check(seq_ready === 1'b0, "R1 ready after reset", 64'(seq_ready), 0);
        check(rd_grant === 1'b0, "R1 R7 grant after reset", 64'(rd_grant), 0);

        // R2: count zero gives ready at once, no frames
        run_and_check("zero", 1'b0);

        // R5 opcode only, R4 two-byte status write sent low byte first
        wr_slot(0, 8'h06, 32'h0, 3'd0, 1'b1);
        wr_slot(1, 8'h01, 32'h0000_C002, 3'd2, 1'b1);
        wr_cnt(2);
        run_and_check("wren_wrsr", 1'b1);
        check(f_bits[0] == 8 && f_val[0][7:0] == 8'h06, "R5 opcode-only frame",
              64'(f_val[0]), 64'h06);
        check(f_val[1][23:0] == 24'h01_02_C0, "R4 byte order", 64'(f_val[1]), 64'h0102C0);

        // R6: length 7 clamps to 4
        wr_slot(0, 8'hA5, 32'h4433_2211, 3'd7, 1'b1);
        wr_cnt(1);
        run_and_check("clamp", 1'b0);
        check(f_val[0] == 40'hA5_11_22_33_44, "R6 clamp content", 64'(f_val[0]),
              64'hA511223344);

        // R9: count above depth runs DEPTH slots
        for (int i = 0; i < DEPTH; i++)
            wr_slot(i, 8'(8'h10 + i), 32'(i * 32'h0101_0101), 3'(i % 6), 1'b1);
        wr_cnt(DEPTH + 5);
        run_and_check("R9 overcount", 1'b0);

        // Random lists, each also checks restart after ready (R11)
        for (int r = 0; r < 6; r++) begin
            int n;
            n = $urandom_range(1, DEPTH);
            for (int i = 0; i < n; i++)
                wr_slot(i, 8'($urandom), 32'($urandom), 3'($urandom_range(0, 7)), 1'b1);
            wr_cnt(n);
            run_and_check("random", (r % 2) == 1);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule